// File: doc/BRIEF.md
# Flash toggle-bit status generator

This block sits on the device side of a parallel flash read path. It produces the two toggle status bits that a host polls while an internal program or erase operation runs. Bit 6 is a device-wide busy indicator. It inverts on every completed host read cycle while an operation is in progress, and it holds its value once the operation ends or an erase is suspended. Bit 2 marks a sector as selected for erase. It inverts only on reads of a sector in the erase-selected mask, and only while an erase is active or suspended. A host that reads twice and compares both bits can therefore tell three things apart: busy or done, erasing or suspended, and which sectors are under erase.

The operation state comes from the erase and program sequencer outside this block. The block also watches the command-accept pulse, which marks the completion of the final write of a command sequence. When that command targets only protected sectors, no real operation starts. In that case the block runs a short fake-busy window of fixed length. The window for a program is `PROG_GUARD_US` microseconds and the window for an erase is `ERASE_GUARD_US` microseconds. Both are converted to clock cycles through `CLK_MHZ`. During the window, bit 6 toggles as if the device were busy. Bits 7 and 5 of the status byte pass straight through from the sequencer. A separate flag tells the output multiplexer whether the current read should return array data or the status byte.

Top module: `flash_toggle_status`

## Requirements
- R1: On each accepted read cycle while `op_state` is program (1), erase (2) or program-during-suspend (4), `status[6]` inverts, whatever sector is read. An accepted read cycle is a high period of `rd_strobe` followed by its fall. The new value is visible from the cycle after the fall.
- R2: While `op_state` is idle (0) and no fake-busy window runs, `status[6]` holds and `array_sel` is 1 for every sector.
- R3: While `op_state` is erase-suspended (3), `status[6]` holds. `array_sel` is 0 when `rd_sector` is in `erase_sel` and 1 otherwise.
- R4: `status[2]` inverts on an accepted read of a sector whose `erase_sel` bit is set, while `op_state` is erase (2) or erase-suspended (3).
- R5: `status[2]` holds on reads of sectors not in `erase_sel`, and on every read in states 0, 1 and 4.
- R6: A `cmd_go` with `cmd_erase`=1 for which no selected sector is unprotected starts a window of `ERASE_GUARD_US*CLK_MHZ` cycles. This includes the case of an empty selection. During the window, reads toggle `status[6]` and `array_sel` is 0. After the window, reads return array data.
- R7: A `cmd_go` with `cmd_erase`=0 whose `cmd_sector` is protected starts a window of `PROG_GUARD_US*CLK_MHZ` cycles. The window behaves as in R6.
- R8: A command whose target includes an unprotected sector starts no window.
- R9: The status byte is {`dq7_in`, bit 6, `dq5_in`, 0, 0, bit 2, 0, 0}, from bit 7 down to bit 0.
- R10: After reset, `status[6]` and `status[2]` are 0.
- R11: A read whose strobe stays high for several cycles counts as one read cycle. The value shown during the high phase is the value from before that read's toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_strobe | input | 1 | High during a host read cycle (chip-enable and output-enable both active) |
| rd_sector | input | SECT_W | Sector index of the read address |
| op_state | input | 3 | 0 idle, 1 program, 2 erase (including time-out), 3 erase-suspended, 4 program during suspend |
| cmd_go | input | 1 | One-cycle pulse on the final write of a command sequence |
| cmd_erase | input | 1 | 1 for an erase command, 0 for a program command |
| cmd_sector | input | SECT_W | Target sector of a program command |
| erase_sel | input | NUM_SECTORS | Sectors selected for erase |
| protect | input | NUM_SECTORS | Protected sectors |
| dq7_in | input | 1 | Bit 7 from the sequencer |
| dq5_in | input | 1 | Bit 5 from the sequencer |
| status | output | 8 | Status byte |
| array_sel | output | 1 | 1 when the read should return array data |

## Verification
The bench builds the block with `NUM_SECTORS`=4 and `CLK_MHZ`=4, which makes the program window 4 cycles and the erase window 400 cycles. With four sectors, the sweep covers all 16 erase-selection masks in every operation state and at every read sector. For the windows, it covers every protection mask against every program target, and several protection masks against all 16 erase selections. The windows are short enough that the bench can observe both the beginning and the end of each one.

// File: rtl/ftsg_pkg.sv
// Package: shared operation-state encoding for the toggle status generator.
// Assumes the sequencer drives exactly these codes.
package ftsg_pkg;
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_ESUSP  = 3'd3,
        OP_ESPROG = 3'd4
    } op_e;
endpackage

// File: rtl/ftsg_read_edge.sv
// Module: detects the end of a host read cycle and keeps the sector read.
// Assumes rd_strobe is already synchronous to clk and that the address
// is stable while the strobe is high.
module ftsg_read_edge #(
    parameter int SECT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic [SECT_W-1:0] rd_sector,
    output logic              rd_done,
    output logic [SECT_W-1:0] done_sector
);
    logic strobe_q;

    // Remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= rd_strobe;
    end

    // Hold the sector seen while the strobe was high.
    always_ff @(posedge clk) begin
        if (!rst_n)         done_sector <= '0;
        else if (rd_strobe) done_sector <= rd_sector;
    end

    // A read cycle is complete on the fall of the strobe.
    assign rd_done = strobe_q & ~rd_strobe;
endmodule

// File: rtl/ftsg_guard_timer.sv
// Module: fake-busy window for commands that hit only protected sectors.
// Assumes cmd_go is a one-cycle pulse. A blocked command reloads the
// window; an accepted command leaves a running window alone.
module ftsg_guard_timer #(
    parameter int NUM_SECTORS = 8,
    parameter int SECT_W      = 3,
    parameter int PROG_CYC    = 100,
    parameter int ERASE_CYC   = 10000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_go,
    input  logic                   cmd_erase,
    input  logic [SECT_W-1:0]      cmd_sector,
    input  logic [NUM_SECTORS-1:0] erase_sel,
    input  logic [NUM_SECTORS-1:0] protect,
    output logic                   guard_active
);
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] remain;
    logic             erase_blocked;
    logic             prog_blocked;

    // A blocked erase has no selected sector left unprotected.
    assign erase_blocked = ((erase_sel & ~protect) == '0);
    assign prog_blocked  = protect[cmd_sector];

    // Load the window on a blocked command, otherwise count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (cmd_go && cmd_erase && erase_blocked)
            remain <= CNT_W'(ERASE_CYC);
        else if (cmd_go && !cmd_erase && prog_blocked)
            remain <= CNT_W'(PROG_CYC);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign guard_active = (remain != '0);
endmodule

// File: rtl/ftsg_toggle_bits.sv
// Module: the two toggle flip-flops and their enable decode.
// Assumes rd_done is high for one cycle per finished read.
module ftsg_toggle_bits
    import ftsg_pkg::*;
#(
    parameter int NUM_SECTORS = 8,
    parameter int SECT_W      = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  op_e                    op,
    input  logic                   guard_active,
    input  logic                   rd_done,
    input  logic [SECT_W-1:0]      done_sector,
    input  logic [NUM_SECTORS-1:0] erase_sel,
    output logic                   busy,
    output logic                   tog_busy,
    output logic                   tog_sect
);
    logic erase_phase;
    logic sect_hit;

    // The device counts as busy while an algorithm runs or a window is open.
    always_comb begin
        busy = guard_active;
        case (op)
            OP_PROG, OP_ERASE, OP_ESPROG: busy = 1'b1;
            default:                      busy = guard_active;
        endcase
    end

    assign erase_phase = (op == OP_ERASE) || (op == OP_ESUSP);
    assign sect_hit    = erase_phase && erase_sel[done_sector];

    // Device-wide toggle: inverts on each finished read while busy.
    always_ff @(posedge clk) begin
        if (!rst_n)                tog_busy <= 1'b0;
        else if (rd_done && busy)  tog_busy <= ~tog_busy;
    end

    // Sector toggle: inverts on finished reads of erase-selected sectors.
    always_ff @(posedge clk) begin
        if (!rst_n)                   tog_sect <= 1'b0;
        else if (rd_done && sect_hit) tog_sect <= ~tog_sect;
    end
endmodule

// File: rtl/flash_toggle_status.sv
// Module: top of the toggle-bit status generator. Builds the status byte
// and the array/status select from the toggle bits and the window timer.
// Assumes NUM_SECTORS is a power of two and all inputs are synchronous.
module flash_toggle_status
    import ftsg_pkg::*;
#(
    parameter int NUM_SECTORS    = 8,
    parameter int SECT_W         = $clog2(NUM_SECTORS),
    parameter int CLK_MHZ        = 100,
    parameter int PROG_GUARD_US  = 1,
    parameter int ERASE_GUARD_US = 100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_strobe,
    input  logic [SECT_W-1:0]      rd_sector,
    input  logic [2:0]             op_state,
    input  logic                   cmd_go,
    input  logic                   cmd_erase,
    input  logic [SECT_W-1:0]      cmd_sector,
    input  logic [NUM_SECTORS-1:0] erase_sel,
    input  logic [NUM_SECTORS-1:0] protect,
    input  logic                   dq7_in,
    input  logic                   dq5_in,
    output logic [7:0]             status,
    output logic                   array_sel
);
    localparam int PROG_CYC  = PROG_GUARD_US * CLK_MHZ;
    localparam int ERASE_CYC = ERASE_GUARD_US * CLK_MHZ;

    op_e               op;
    logic              rd_done;
    logic [SECT_W-1:0] done_sector;
    logic              guard_active;
    logic              busy;
    logic              tog_busy;
    logic              tog_sect;

    assign op = op_e'(op_state);

    ftsg_read_edge #(.SECT_W(SECT_W)) edge_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_strobe   (rd_strobe),
        .rd_sector   (rd_sector),
        .rd_done     (rd_done),
        .done_sector (done_sector)
    );

    ftsg_guard_timer #(
        .NUM_SECTORS (NUM_SECTORS),
        .SECT_W      (SECT_W),
        .PROG_CYC    (PROG_CYC),
        .ERASE_CYC   (ERASE_CYC)
    ) guard_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_go       (cmd_go),
        .cmd_erase    (cmd_erase),
        .cmd_sector   (cmd_sector),
        .erase_sel    (erase_sel),
        .protect      (protect),
        .guard_active (guard_active)
    );

    ftsg_toggle_bits #(
        .NUM_SECTORS (NUM_SECTORS),
        .SECT_W      (SECT_W)
    ) tog_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .guard_active (guard_active),
        .rd_done      (rd_done),
        .done_sector  (done_sector),
        .erase_sel    (erase_sel),
        .busy         (busy),
        .tog_busy     (tog_busy),
        .tog_sect     (tog_sect)
    );

    // Status reads apply while busy, or for suspended sectors under erase.
    assign array_sel = ~(busy || ((op == OP_ESUSP) && erase_sel[rd_sector]));

    // Status byte layout: pass-through bits around the two toggles.
    assign status = {dq7_in, tog_busy, dq5_in, 1'b0, 1'b0, tog_sect, 1'b0, 1'b0};
endmodule

// File: rtl/ftsg_checker.sv
// Module: property checker for flash_toggle_status, attached by bind.
// Assumes the same parameters as the checked instance.
module ftsg_checker #(
    parameter int NUM_SECTORS = 8,
    parameter int SECT_W      = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rd_strobe,
    input logic [2:0]             op_state,
    input logic                   cmd_go,
    input logic                   cmd_erase,
    input logic [SECT_W-1:0]      cmd_sector,
    input logic [NUM_SECTORS-1:0] erase_sel,
    input logic [NUM_SECTORS-1:0] protect,
    input logic                   dq7_in,
    input logic                   dq5_in,
    input logic [7:0]             status,
    input logic                   array_sel,
    input logic                   guard_active
);
    logic prev_strobe;
    logic rd_fall;
    logic op_busy;

    // Checker copy of the strobe history for read-end detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_strobe <= 1'b0;
        else        prev_strobe <= rd_strobe;
    end

    assign rd_fall = prev_strobe && !rd_strobe;
    assign op_busy = (op_state == 3'd1) || (op_state == 3'd2) || (op_state == 3'd4);

    a_r1_busy_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fall && op_busy) |=> (status[6] != $past(status[6])));

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state == 3'd0 && !guard_active) |=> $stable(status[6]));

    a_r3_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state == 3'd3 && !guard_active) |=> $stable(status[6]));

    a_r5_sect_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_state != 3'd2 && op_state != 3'd3) |=> $stable(status[2]));

    a_r6_erase_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && cmd_erase && ((erase_sel & ~protect) == '0)) |=> (guard_active && !array_sel));

    a_r7_prog_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !cmd_erase && protect[cmd_sector]) |=> (guard_active && !array_sel));

    a_r1_busy_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy |-> !array_sel);

    a_r9_layout: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] == dq7_in && status[5] == dq5_in && status[4:3] == 2'b00 && status[1:0] == 2'b00));
endmodule

bind flash_toggle_status ftsg_checker #(
    .NUM_SECTORS (NUM_SECTORS),
    .SECT_W      (SECT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_strobe    (rd_strobe),
    .op_state     (op_state),
    .cmd_go       (cmd_go),
    .cmd_erase    (cmd_erase),
    .cmd_sector   (cmd_sector),
    .erase_sel    (erase_sel),
    .protect      (protect),
    .dq7_in       (dq7_in),
    .dq5_in       (dq5_in),
    .status       (status),
    .array_sel    (array_sel),
    .guard_active (guard_active)
);

// File: tb/flash_toggle_status_tb_top.sv
// Bench: sweeps the operation states, sector masks and protection cases
// of a 4-sector build and predicts every status read arithmetically.
module flash_toggle_status_tb_top;
    localparam int NS    = 4;
    localparam int SW    = 2;
    localparam int MHZ   = 4;
    localparam int PCYC  = 1 * MHZ;
    localparam int ECYC  = 100 * MHZ;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_strobe = 1'b0;
    logic [SW-1:0] rd_sector = '0;
    logic [2:0]    op_state = 3'd0;
    logic          cmd_go = 1'b0;
    logic          cmd_erase = 1'b0;
    logic [SW-1:0] cmd_sector = '0;
    logic [NS-1:0] erase_sel = '0;
    logic [NS-1:0] protect = '0;
    logic          dq7_in = 1'b0;
    logic          dq5_in = 1'b0;
    logic [7:0]    status;
    logic          array_sel;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic exp6 = 1'b0;
    logic exp2 = 1'b0;
    int   g_load = -100000;
    int   g_len = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_toggle_status #(
        .NUM_SECTORS (NS),
        .SECT_W      (SW),
        .CLK_MHZ     (MHZ),
        .PROG_GUARD_US (1),
        .ERASE_GUARD_US (100)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .rd_strobe (rd_strobe), .rd_sector (rd_sector),
        .op_state (op_state), .cmd_go (cmd_go), .cmd_erase (cmd_erase),
        .cmd_sector (cmd_sector), .erase_sel (erase_sel), .protect (protect),
        .dq7_in (dq7_in), .dq5_in (dq5_in), .status (status), .array_sel (array_sel)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (op=%0d cyc=%0d)", req, act, exp, op_state, cyc);
        end
    endtask

    function automatic bit op_busy();
        return (op_state == 3'd1) || (op_state == 3'd2) || (op_state == 3'd4);
    endfunction

    // One host read; hold = extra high cycles. Checks the value shown
    // during the read, then updates the expectation at the fall edge.
    task automatic do_read(input int sec, input int hold, input string req);
        bit g_now;
        bit hit;
        @(negedge clk);
        rd_sector = SW'(sec);
        rd_strobe = 1'b1;
        for (int i = 0; i <= hold; i++) begin
            @(negedge clk);
            g_now = (g_len > 0) && (cyc >= g_load) && (cyc < g_load + g_len);
            check({req, " bit6"}, {7'd0, status[6]}, {7'd0, exp6});
            check({req, " bit2"}, {7'd0, status[2]}, {7'd0, exp2});
            check({req, " array_sel"}, {7'd0, array_sel},
                  {7'd0, !(op_busy() || g_now || (op_state == 3'd3 && erase_sel[sec]))});
        end
        rd_strobe = 1'b0;
        @(negedge clk);
        g_now = (g_len > 0) && (cyc > g_load) && (cyc <= g_load + g_len);
        hit = (op_state == 3'd2 || op_state == 3'd3) && erase_sel[sec];
        if (op_busy() || g_now) exp6 = ~exp6;
        if (hit) exp2 = ~exp2;
    endtask

    task automatic issue(input bit erase, input int sec);
        bit blocked;
        @(negedge clk);
        cmd_go = 1'b1;
        cmd_erase = erase;
        cmd_sector = SW'(sec);
        blocked = erase ? ((erase_sel & ~protect) == '0) : protect[sec];
        @(negedge clk);
        cmd_go = 1'b0;
        if (blocked) begin
            g_load = cyc;
            g_len = erase ? ECYC : PCYC;
        end
    endtask

    task automatic wait_window();
        while (cyc <= g_load + g_len + 1) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset values of the toggle bits, idle array select
        check("R10 reset bit6", {7'd0, status[6]}, 8'd0);
        check("R10 reset bit2", {7'd0, status[2]}, 8'd0);
        check("R2 reset array_sel", {7'd0, array_sel}, 8'd1);

        // R9: pass-through and constant bit positions
        for (int v = 0; v < 4; v++) begin
            dq7_in = v[1];
            dq5_in = v[0];
            @(negedge clk);
            check("R9 layout", status & 8'hBB, {v[1], 1'b0, v[0], 5'd0});
        end
        dq7_in = 1'b0;
        dq5_in = 1'b0;

        // R1 R2 R3 R4 R5: every state, every erase mask, every sector
        for (int op = 0; op < 5; op++) begin
            for (int m = 0; m < 16; m++) begin
                @(negedge clk);
                op_state = 3'(op);
                erase_sel = NS'(m);
                for (int s = 0; s < NS; s++) begin
                    do_read(s, 0, "R1-state sweep");
                    do_read(s, 0, "R4 R5 repeat read");
                end
            end
        end

        // R11: long strobe counts once
        @(negedge clk);
        op_state = 3'd2;
        erase_sel = 4'b0101;
        do_read(0, 3, "R11 long read");
        do_read(2, 2, "R11 long read");
        do_read(1, 4, "R11 long read");
        @(negedge clk);
        op_state = 3'd0;
        erase_sel = '0;

        // R7 R8: program windows over all protect masks and targets
        for (int p = 0; p < 16; p++) begin
            for (int s = 0; s < NS; s++) begin
                @(negedge clk);
                protect = NS'(p);
                issue(1'b0, s);
                do_read(s, 0, "R7 prog window");
                do_read((s + 1) % NS, 0, "R7 R8 prog window");
                wait_window();
                do_read(s, 0, "R7 after window");
            end
        end

        // R6 R8: erase windows over all erase masks
        for (int m = 0; m < 16; m++) begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                erase_sel = NS'(m);
                protect = (k == 0) ? 4'h0 : (k == 1) ? 4'h5 : (k == 2) ? 4'hF : NS'(m);
                issue(1'b1, 0);
                do_read(0, 0, "R6 erase window");
                do_read(3, 0, "R6 R8 erase window");
                wait_window();
                do_read(1, 0, "R6 after window");
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule